// File: doc/BRIEF.md
# Trigger-Started External-Event Counter

This block is an up-counter that never counts on the system clock. It waits, frozen at its current value, until a trigger input shows an active edge. That edge sets a counter-enable bit and raises a sticky trigger flag. From then on, each active edge on a second input, the event pin, advances the count by one. Both inputs are asynchronous to the system clock. Each one passes through a synchronizer and an edge detector before the control logic sees it.

Control inputs work like register fields. They choose the active edge of each pin and switch event counting on or off. Two codes together decide whether the counter may run: a 3-bit slave-mode code and a 3-bit trigger-source code. Only one combination of the two is supported. Software can clear the counter-enable bit and the trigger flag. The count wraps back to zero, and the block pulses an overflow output for one cycle when it wraps.

Top module: `trig_ext_counter`

## Requirements
- R1: While reset is asserted and after it is released, `count` is 0, and `cnt_en`, `trig_flag` and `wrap_pulse` are 0.
- R2: Assume `slave_mode` = 3'b110, `trig_src` = 3'b101 and `trig_fall` = 0. A rising edge on `trig_pin` sets `cnt_en` and `trig_flag`. Both outputs are visible after the fourth rising clock edge that follows the pin change.
- R3: With `trig_fall` = 1, only falling edges on `trig_pin` act as triggers. Rising edges leave `cnt_en` at 0.
- R4: While `cnt_en` is 0, edges on `evt_pin` leave `count` unchanged.
- R5: Assume `cnt_en` = 1, `evt_en` = 1 and `evt_fall` = 0. Each rising edge on `evt_pin` adds exactly one to `count`. The new value is visible after the fourth rising clock edge that follows the pin change.
- R6: With `evt_fall` = 1, each falling edge on `evt_pin` counts, and no rising edge does.
- R7: With `evt_en` = 0, edges on `evt_pin` leave `count` unchanged.
- R8: Later trigger edges neither reset nor restart `count`. `cnt_en` stays at 1 until `cnt_en_clr` is asserted. After that, event edges are not counted until the next trigger edge. Counting then resumes from the value that was held.
- R9: `trig_flag` stays at 1 until `trig_flag_clr` is asserted. If the clear arrives in the same cycle as a detected trigger edge, `trig_flag` remains 1.
- R10: An event counted at the all-ones value makes `count` wrap to 0. `wrap_pulse` is 1 for exactly that one cycle.
- R11: Any `slave_mode` other than 3'b110, or any `trig_src` other than 3'b101, means triggers do not set `cnt_en` and events do not change `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_pin | input | 1 | Asynchronous trigger input |
| evt_pin | input | 1 | Asynchronous event (count) input |
| trig_fall | input | 1 | 0: rising trigger edges are active, 1: falling |
| evt_fall | input | 1 | 0: rising event edges count, 1: falling |
| evt_en | input | 1 | Enables counting on event-pin edges |
| slave_mode | input | 3 | Slave-mode code; 3'b110 selects trigger start |
| trig_src | input | 3 | Trigger-source code; 3'b101 selects `trig_pin` |
| cnt_en_clr | input | 1 | Clears the counter-enable bit |
| trig_flag_clr | input | 1 | Write-one-to-clear for the trigger flag |
| count | output | CNT_W | Current count |
| cnt_en | output | 1 | Counter-enable status |
| trig_flag | output | 1 | Sticky trigger flag |
| wrap_pulse | output | 1 | One-cycle pulse when the count wraps to 0 |

## Verification
The bench builds the block with an 8-bit count and keeps the default two synchronizer stages. The narrow count means the all-ones value is reached after 255 events, so the wrap and its one-cycle pulse can be checked within a short run. Two synchronizer stages fix the detection latency at four clock edges, and every check is timed to that latency.

// File: rtl/trig_cnt_pkg.sv
package trig_cnt_pkg;
  localparam logic [2:0] SLV_TRIG_START = 3'b110;
  localparam logic [2:0] SRC_TRIG_PIN   = 3'b101;
  localparam int         PIN_TRIG       = 0;
  localparam int         PIN_EVT        = 1;
  localparam int         NUM_PINS       = 2;
endpackage

// File: rtl/trc_edge_sync.sv
module trc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic pulse
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sync_q, sync_d;
  logic         prev_q, prev_d;
  logic         pulse_q, pulse_d;

  always_comb begin
    sync_d  = {sync_q[TOP-1:0], pin};
    prev_d  = sync_q[TOP];
    pulse_d = fall_sel ? (prev_q & ~sync_q[TOP]) : (~prev_q & sync_q[TOP]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= prev_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_ok,
  input  logic trig,
  input  logic cen_clr,
  input  logic flag_clr,
  output logic cen,
  output logic flag
);
  logic cen_q, cen_d;
  logic flag_q, flag_d;
  logic start;

  always_comb begin
    start  = mode_ok & trig;
    cen_d  = cen_q;
    flag_d = flag_q;
    if (start)        cen_d = 1'b1;
    else if (cen_clr) cen_d = 1'b0;
    if (start)         flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cen_q  <= cen_d;
      flag_q <= flag_d;
    end
  end

  assign cen  = cen_q;
  assign flag = flag_q;

  // R8
  cen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && !cen_clr) |=> cen);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  // R9
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ok && trig && flag_clr) |=> flag);
  // R11
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ok && !cen) |=> !cen);
endmodule

// File: rtl/trc_counter.sv
module trc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (step) begin
      cnt_d  = cnt_q + ONE;
      wrap_d = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign count = cnt_q;
  assign wrap  = wrap_q;

  // R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE));
  // R10
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (cnt_q == '0));
endmodule

// File: rtl/trig_ext_counter.sv
module trig_ext_counter
  import trig_cnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_pin,
  input  logic             evt_pin,
  input  logic             trig_fall,
  input  logic             evt_fall,
  input  logic             evt_en,
  input  logic [2:0]       slave_mode,
  input  logic [2:0]       trig_src,
  input  logic             cnt_en_clr,
  input  logic             trig_flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             cnt_en,
  output logic             trig_flag,
  output logic             wrap_pulse
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [NUM_PINS-1:0] pin_v, fall_v, pulse_v;
  logic                mode_ok;
  logic                step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pin_v[PIN_TRIG]  = trig_pin;
  assign pin_v[PIN_EVT]   = evt_pin;
  assign fall_v[PIN_TRIG] = trig_fall;
  assign fall_v[PIN_EVT]  = evt_fall;

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    trc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .pin      (pin_v[gi]),
      .fall_sel (fall_v[gi]),
      .pulse    (pulse_v[gi])
    );
  end

  assign mode_ok = (slave_mode == SLV_TRIG_START) && (trig_src == SRC_TRIG_PIN);
  assign step    = pulse_v[PIN_EVT] & cnt_en & mode_ok & evt_en;

  trc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .mode_ok  (mode_ok),
    .trig     (pulse_v[PIN_TRIG]),
    .cen_clr  (cnt_en_clr),
    .flag_clr (trig_flag_clr),
    .cen      (cnt_en),
    .flag     (trig_flag)
  );

  trc_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (step),
    .count (count),
    .wrap  (wrap_pulse)
  );

  // R4
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cnt_en |=> (count == $past(count)));
  // R7
  evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !evt_en |=> (count == $past(count)));
  // R11
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mode_ok |=> (count == $past(count)));
endmodule

// File: tb/sim_trig_ext_counter.sv
module sim_trig_ext_counter;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trig_pin, evt_pin, trig_fall, evt_fall, evt_en;
  logic [2:0]    slave_mode, trig_src;
  logic          cnt_en_clr, trig_flag_clr;
  logic [BW-1:0] count;
  logic          cnt_en, trig_flag, wrap_pulse;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // vector: [15] evt_fall, [14] evt_en, [13:8] edges, [7:0] expected increment
  localparam logic [15:0] VEC [5] = '{
    {1'b0, 1'b1, 6'd3, 8'd3},
    {1'b1, 1'b1, 6'd2, 8'd2},
    {1'b0, 1'b0, 6'd3, 8'd0},
    {1'b1, 1'b0, 6'd1, 8'd0},
    {1'b0, 1'b1, 6'd5, 8'd5}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_ext_counter #(.CNT_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .evt_pin(evt_pin),
    .trig_fall(trig_fall), .evt_fall(evt_fall), .evt_en(evt_en),
    .slave_mode(slave_mode), .trig_src(trig_src),
    .cnt_en_clr(cnt_en_clr), .trig_flag_clr(trig_flag_clr),
    .count(count), .cnt_en(cnt_en), .trig_flag(trig_flag),
    .wrap_pulse(wrap_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one event edge of either polarity: line idles low
  task automatic evt_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      evt_pin = 1'b1; nwait(2);
      evt_pin = 1'b0; nwait(2);
    end
    nwait(4);
  endtask

  task automatic trig_pulse();
    trig_pin = 1'b1; nwait(4);
    trig_pin = 1'b0; nwait(4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; nwait(3);
    chk("R1 count in reset", count, 0);
    chk("R1 cen in reset", cnt_en, 0);
    rst_n = 1'b1; nwait(4);
  endtask

  initial begin
    logic [BW-1:0] base;
    rst_n = 1'b0; trig_pin = 0; evt_pin = 0; trig_fall = 0; evt_fall = 0;
    evt_en = 1; slave_mode = 3'b000; trig_src = 3'b101;
    cnt_en_clr = 0; trig_flag_clr = 0;
    do_reset();
    chk("R1 count", count, 0);
    chk("R1 cen", cnt_en, 0);
    chk("R1 flag", trig_flag, 0);
    chk("R1 wrap", wrap_pulse, 0);

    // R11: wrong slave mode, then wrong source
    trig_pulse();
    chk("R11 mode 000 cen", cnt_en, 0);
    chk("R11 mode 000 flag", trig_flag, 0);
    slave_mode = 3'b110; trig_src = 3'b100;
    trig_pulse();
    chk("R11 src 100 cen", cnt_en, 0);
    evt_pulses(2);
    chk("R11 src 100 count", count, 0);

    // R4: correct codes, no trigger yet
    trig_src = 3'b101;
    evt_pulses(3);
    chk("R4 count before trigger", count, 0);

    // R2: trigger, observed on fourth edge after pin change
    trig_pin = 1'b1; nwait(3);
    chk("R2 cen not yet", cnt_en, 0);
    nwait(1);
    chk("R2 cen set", cnt_en, 1);
    chk("R2 flag set", trig_flag, 1);
    trig_pin = 1'b0; nwait(4);

    // R5 latency
    evt_pin = 1'b1; nwait(3);
    chk("R5 count before latency", count, 0);
    nwait(1);
    chk("R5 count after latency", count, 1);
    evt_pin = 1'b0; nwait(4);

    // R5 R6 R7 table
    base = count;
    for (int i = 0; i < 5; i++) begin
      evt_fall = VEC[i][15];
      evt_en   = VEC[i][14];
      evt_pulses(int'(VEC[i][13:8]));
      base = base + VEC[i][BW-1:0];
      chk(VEC[i][14] ? (VEC[i][15] ? "R6 falling events" : "R5 rising events")
                     : "R7 events disabled", count, base);
    end
    evt_fall = 0; evt_en = 1;

    // R8: retrigger does not reset count
    trig_pulse();
    chk("R8 retrigger keeps count", count, base);
    cnt_en_clr = 1; nwait(1); cnt_en_clr = 0;
    chk("R8 cen cleared", cnt_en, 0);
    evt_pulses(2);
    chk("R8 no count after clear", count, base);
    trig_pulse();
    chk("R8 cen reset by trigger", cnt_en, 1);
    evt_pulses(1);
    chk("R8 resumes from held", count, base + 1'b1);

    // R9: clear, then clear coinciding with trigger
    trig_flag_clr = 1; nwait(1); trig_flag_clr = 0;
    chk("R9 flag cleared", trig_flag, 0);
    nwait(3);
    chk("R9 flag stays clear", trig_flag, 0);
    trig_pin = 1'b1; nwait(3);
    trig_flag_clr = 1; nwait(1); trig_flag_clr = 0;
    chk("R9 set wins over clear", trig_flag, 1);
    trig_pin = 1'b0; nwait(4);
    chk("R9 flag sticky", trig_flag, 1);

    // R3: falling-edge trigger
    do_reset();
    trig_fall = 1;
    trig_pin = 1'b1; nwait(5);
    chk("R3 rising ignored", cnt_en, 0);
    trig_pin = 1'b0; nwait(4);
    chk("R3 falling triggers", cnt_en, 1);
    nwait(2);

    // R10: wrap
    evt_pulses(255);
    chk("R10 all ones", count, 8'hFF);
    chk("R10 no early wrap", wrap_pulse, 0);
    evt_pin = 1'b1; nwait(4);
    chk("R10 wrapped count", count, 0);
    chk("R10 wrap pulse", wrap_pulse, 1);
    nwait(1);
    chk("R10 wrap one cycle", wrap_pulse, 0);
    evt_pin = 1'b0; nwait(4);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule